// File: doc/BRIEF.md
# Broadcast Outer-Product Accumulation Mesh

This block is a square array of N×N multiply-accumulate elements, N a power of two, that holds the result tile of a matrix product in place. Each cycle it can take one column vector of the left operand and one row vector of the right operand. It registers them once and broadcasts them: the left-operand element of row r goes to every element in row r, and the right-operand element of column c goes to every element in column c. Every element then adds its signed product into its accumulator. Operands never travel from element to element, so the only operand staging is 2·N registers.

Each element keeps P accumulators in a rotating ring, where P is the pipeline depth. Consecutive updates therefore land in different slots, and the mesh holds P interleaved output tiles at once. Update number u of a tile, counted from zero, goes to slot u mod P. Results leave through a shadow copy of every ring. Each mesh row links its shadows into one shift chain of N·P entries. While the next tile computes, finished results leave at the east end of the chain and the initial values of a later tile enter at the west end.

A controller runs the phases. It does one preload-only pass at start, then exchanges ring and shadow at each tile boundary with no lost update cycle, then does one drain-only pass after the last tile, and finally raises a one-cycle done pulse.

Top module: `outer_mesh`

## Requirements
- R1: After reset, `ab_ready`, `pre_take`, `res_valid`, `busy` and `done` are all low.
- R2: A `start` with nonzero `k_len` and `tile_cnt` begins a preload pass of exactly N·P `pre_take` cycles, and no update is accepted before that pass ends.
- R3: An accepted update (when `ab_valid` and `ab_ready` are both high) adds the signed product a[r]·b[c] into element (r,c), slot u mod P, where u is the update's index within its tile. Operand element r sits at bits [r·DW +: DW]. The accumulator wraps at AW bits.
- R4: Each result equals its preloaded initial value plus the sum of all products that reached its slot during the tile's `k_len` updates. `k_len` is a multiple of P.
- R5: Each pass moves N·P values per row. Row r uses bits [r·AW +: AW] of `c_in` and `c_out`. In shift cycle s (0-based), the value on `c_out` and the value taken from `c_in` both belong to chain position q = N·P−1−s, which is column q/P, slot q mod P. A ring/shadow exchange never happens in a cycle that shifts.
- R6: Preload values are consumed in tile order: tile 0, then tile 1, and so on. Results are delivered in tile order. Tile t's results leave in the same pass that loads tile t+2's initial values.
- R7: When `k_len` > N·P, `ab_ready` stays high for exactly `tile_cnt`·`k_len` consecutive accepting cycles, with no bubble at tile boundaries.
- R8: When a shift pass is still running, the last update of a tile is held off until the pass ends. The results stay correct.
- R9: `done` is high for exactly one cycle, in the cycle right after the last result was presented, and `busy` is low from that cycle on.
- R10: `ab_valid` and operand values while `ab_ready` is low, and `c_in` values while `pre_take` is low, have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| k_len | input | KW | Updates per tile, a multiple of P |
| tile_cnt | input | TW | Number of tiles in the run |
| ab_valid | input | 1 | Operand vectors present |
| ab_ready | output | 1 | Mesh takes the operands this cycle |
| a_vec | input | N·DW | Left-operand column, signed, one element per row |
| b_vec | input | N·DW | Right-operand row, signed, one element per column |
| pre_take | output | 1 | `c_in` is shifted in this cycle |
| c_in | input | N·AW | Initial values, one per mesh row |
| res_valid | output | 1 | `c_out` carries a result this cycle |
| c_out | output | N·AW | Results, one per mesh row |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final result |

## Verification
The bench uses the default build: N=4, P=2, DW=8, AW=24, so each row chain is 8 deep. With this size, `k_len` values of 2 and 4 force the controller to hold back the last update of a tile behind a running pass. Values of 10 and 16 show accepts with no gaps across every tile boundary. Tile counts from 1 to 4 cover the single-tile case and the case where the drain of one tile overlaps the load of the tile two ahead. Every result word is compared against a product computed in the bench, using random full-range signed operands and random junk on inputs that must be ignored.

// File: rtl/outer_mesh_pkg.sv
package outer_mesh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD0,
    ST_ARM,
    ST_RUN,
    ST_FLUSH
  } mesh_state_t;

endpackage

// File: rtl/outer_mesh_pe.sv
module outer_mesh_pe #(
  parameter int P  = 2,
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          swap_en,
  input  logic          shift_en,
  input  logic [AW-1:0] sh_in,
  output logic [AW-1:0] sh_out
);

  // signed product, sign-extended into the accumulator width, wrapping add
  function automatic logic [AW-1:0] mac(input logic [AW-1:0] acc,
                                        input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    logic signed [2*DW-1:0] prod;
    prod = $signed(a) * $signed(b);
    return acc + AW'(prod);
  endfunction

  logic [AW-1:0] ring_q   [P];
  logic [AW-1:0] ring_nx  [P];
  logic [AW-1:0] shadow_q [P];

  // ring rotates on each update; head slot gets the product and moves to the tail
  always_comb begin
    for (int i = 0; i < P; i++) ring_nx[i] = ring_q[i];
    if (upd_en) begin
      for (int i = 0; i < P - 1; i++) ring_nx[i] = ring_q[i+1];
      ring_nx[P-1] = mac(ring_q[0], a_in, b_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) begin
        ring_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else if (swap_en) begin
      for (int i = 0; i < P; i++) begin
        ring_q[i]   <= shadow_q[i];
        shadow_q[i] <= ring_nx[i];
      end
    end else begin
      for (int i = 0; i < P; i++) ring_q[i] <= ring_nx[i];
      if (shift_en) begin
        shadow_q[0] <= sh_in;
        for (int i = 1; i < P; i++) shadow_q[i] <= shadow_q[i-1];
      end
    end
  end

  assign sh_out = shadow_q[P-1];

endmodule

// File: rtl/outer_mesh_ctrl.sv
module outer_mesh_ctrl
  import outer_mesh_pkg::*;
#(
  parameter int N  = 4,
  parameter int P  = 2,
  parameter int KW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_len,
  input  logic [TW-1:0] tile_cnt,
  input  logic          ab_valid,
  output logic          ab_ready,
  output logic          accept,
  output logic          last_accept,
  output logic          upd_en,
  output logic          swap_en,
  output logic          shift_en,
  output logic          shift_busy,
  output logic          pre_take,
  output logic          res_valid,
  output logic          busy,
  output logic          done
);

  localparam int SHL = N * P;
  localparam int SCW = (SHL > 1) ? $clog2(SHL) : 1;

  mesh_state_t   state;
  logic [KW-1:0] k_q, kcnt;
  logic [TW-1:0] t_q, tcnt;
  logic [SCW-1:0] sh_cnt;
  logic          sh_busy, sh_load, sh_out;
  logic          swap_pend, load_pend, upd_q, done_q;
  logic          last_k, shift_end, more_ahead;

  assign last_k     = (kcnt == k_q - KW'(1));
  assign shift_end  = sh_busy && (sh_cnt == SCW'(SHL - 1));
  assign ab_ready   = (state == ST_RUN) && (!last_k || !sh_busy);
  assign accept     = ab_ready && ab_valid;
  assign last_accept = accept && last_k;
  assign more_ahead = ((TW+1)'(tcnt) + (TW+1)'(2)) < (TW+1)'(t_q);

  assign upd_en     = upd_q;
  assign swap_en    = (state == ST_ARM) || swap_pend;
  assign shift_en   = sh_busy;
  assign shift_busy = sh_busy;
  assign pre_take   = sh_busy && sh_load;
  assign res_valid  = sh_busy && sh_out;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      k_q       <= '0;
      t_q       <= '0;
      kcnt      <= '0;
      tcnt      <= '0;
      sh_cnt    <= '0;
      sh_busy   <= 1'b0;
      sh_load   <= 1'b0;
      sh_out    <= 1'b0;
      swap_pend <= 1'b0;
      load_pend <= 1'b0;
      upd_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      upd_q     <= accept;
      swap_pend <= last_accept;
      done_q    <= 1'b0;

      if (sh_busy) begin
        if (shift_end) begin
          sh_busy <= 1'b0;
          sh_cnt  <= '0;
        end else begin
          sh_cnt <= sh_cnt + SCW'(1);
        end
      end

      // the exchange at a tile boundary launches a drain pass
      if (swap_pend) begin
        sh_busy <= 1'b1;
        sh_cnt  <= '0;
        sh_load <= load_pend;
        sh_out  <= 1'b1;
      end

      unique case (state)
        ST_IDLE: begin
          if (start && (k_len != '0) && (tile_cnt != '0)) begin
            k_q     <= k_len;
            t_q     <= tile_cnt;
            kcnt    <= '0;
            tcnt    <= '0;
            sh_busy <= 1'b1;
            sh_cnt  <= '0;
            sh_load <= 1'b1;
            sh_out  <= 1'b0;
            state   <= ST_LOAD0;
          end
        end
        ST_LOAD0: begin
          if (shift_end) state <= ST_ARM;
        end
        ST_ARM: begin
          state <= ST_RUN;
          if (t_q > TW'(1)) begin
            sh_busy <= 1'b1;
            sh_cnt  <= '0;
            sh_load <= 1'b1;
            sh_out  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (accept) begin
            if (last_k) begin
              kcnt      <= '0;
              load_pend <= more_ahead;
              if (tcnt == t_q - TW'(1)) state <= ST_FLUSH;
              else tcnt <= tcnt + TW'(1);
            end else begin
              kcnt <= kcnt + KW'(1);
            end
          end
        end
        ST_FLUSH: begin
          if (!swap_pend && shift_end) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/outer_mesh.sv
module outer_mesh #(
  parameter int N  = 4,
  parameter int P  = 2,
  parameter int DW = 8,
  parameter int AW = 24,
  parameter int KW = 8,
  parameter int TW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [KW-1:0]   k_len,
  input  logic [TW-1:0]   tile_cnt,
  input  logic            ab_valid,
  output logic            ab_ready,
  input  logic [N*DW-1:0] a_vec,
  input  logic [N*DW-1:0] b_vec,
  output logic            pre_take,
  input  logic [N*AW-1:0] c_in,
  output logic            res_valid,
  output logic [N*AW-1:0] c_out,
  output logic            busy,
  output logic            done
);

  // named internal events, observed by the bound checker
  logic accept, last_accept, upd_en, swap_fire, shift_fire, shift_busy;

  logic [N*DW-1:0] a_q, b_q;
  logic [AW-1:0]   sh_link [N][N];

  outer_mesh_ctrl #(.N(N), .P(P), .KW(KW), .TW(TW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .k_len      (k_len),
    .tile_cnt   (tile_cnt),
    .ab_valid   (ab_valid),
    .ab_ready   (ab_ready),
    .accept     (accept),
    .last_accept(last_accept),
    .upd_en     (upd_en),
    .swap_en    (swap_fire),
    .shift_en   (shift_fire),
    .shift_busy (shift_busy),
    .pre_take   (pre_take),
    .res_valid  (res_valid),
    .busy       (busy),
    .done       (done)
  );

  // broadcast staging: 2*N words, the only operand storage in the mesh
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_vec;
      b_q <= b_vec;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [AW-1:0] pe_in;
      if (c == 0) begin : g_west
        assign pe_in = c_in[r*AW +: AW];
      end else begin : g_link
        assign pe_in = sh_link[r][c-1];
      end
      outer_mesh_pe #(.P(P), .DW(DW), .AW(AW)) u_pe (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .a_in    (a_q[r*DW +: DW]),
        .b_in    (b_q[c*DW +: DW]),
        .swap_en (swap_fire),
        .shift_en(shift_fire),
        .sh_in   (pe_in),
        .sh_out  (sh_link[r][c])
      );
    end
    assign c_out[r*AW +: AW] = sh_link[r][N-1];
  end

endmodule

// File: rtl/outer_mesh_chk.sv
module outer_mesh_chk (
  input logic clk,
  input logic rst_n,
  input logic ab_ready,
  input logic busy,
  input logic res_valid,
  input logic done,
  input logic swap_fire,
  input logic shift_fire,
  input logic last_accept,
  input logic shift_busy
);

  a_r1_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    ab_ready |-> busy);

  a_r5_swap_not_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |-> !shift_fire);

  a_r6_results_inside_run: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  a_r8_last_update_waits: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |-> !shift_busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(res_valid) && !busy));

endmodule

bind outer_mesh outer_mesh_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ab_ready   (ab_ready),
  .busy       (busy),
  .res_valid  (res_valid),
  .done       (done),
  .swap_fire  (swap_fire),
  .shift_fire (shift_fire),
  .last_accept(last_accept),
  .shift_busy (shift_busy)
);

// File: tb/test_outer_mesh.sv
`timescale 1ns/1ps
module test_outer_mesh;

  localparam int N  = 4;
  localparam int P  = 2;
  localparam int DW = 8;
  localparam int AW = 24;
  localparam int KW = 8;
  localparam int TW = 4;
  localparam int NP = N * P;
  localparam int MAXT = 4;
  localparam int MAXK = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [KW-1:0]   k_len = '0;
  logic [TW-1:0]   tile_cnt = '0;
  logic            ab_valid = 1'b0;
  logic            ab_ready;
  logic [N*DW-1:0] a_vec = '0;
  logic [N*DW-1:0] b_vec = '0;
  logic            pre_take;
  logic [N*AW-1:0] c_in = '0;
  logic            res_valid;
  logic [N*AW-1:0] c_out;
  logic            busy;
  logic            done;

  int n_checks = 0;
  int n_fail = 0;

  int init_m [MAXT][N][N][P];
  int exp_m  [MAXT][N][N][P];
  int av     [MAXT][MAXK][N];
  int bv     [MAXT][MAXK][N];

  always #2.5 clk = ~clk;

  outer_mesh #(.N(N), .P(P), .DW(DW), .AW(AW), .KW(KW), .TW(TW)) i_outer_mesh (
    .clk(clk), .rst_n(rst_n), .start(start), .k_len(k_len), .tile_cnt(tile_cnt),
    .ab_valid(ab_valid), .ab_ready(ab_ready), .a_vec(a_vec), .b_vec(b_vec),
    .pre_take(pre_take), .c_in(c_in), .res_valid(res_valid), .c_out(c_out),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int srand8();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic run_case(input int k, input int t);
    int cyc = 0, lc = 0, oc = 0, uc = 0;
    int first_acc = -1, last_acc = -1, pre_before = 0;
    int done_cnt = 0, done_cyc = -1, last_res = -1;
    bit fin = 1'b0;
    // build operands and the reference product
    for (int tt = 0; tt < t; tt++) begin
      for (int u = 0; u < k; u++)
        for (int r = 0; r < N; r++) begin
          av[tt][u][r] = srand8();
          bv[tt][u][r] = srand8();
        end
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          for (int s = 0; s < P; s++) begin
            init_m[tt][r][c][s] = int'($urandom_range(0, 4000)) - 2000;
            exp_m[tt][r][c][s]  = init_m[tt][r][c][s];
            for (int u = s; u < k; u += P)
              exp_m[tt][r][c][s] += av[tt][u][r] * bv[tt][u][c];
          end
    end
    @(negedge clk);
    start = 1'b1; k_len = KW'(k); tile_cnt = TW'(t);
    while (!fin) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (fin == 1'b0 && done_cyc >= 0) begin
        check(!done, "R9", "done lasts one cycle", longint'(done), 0);
        fin = 1'b1;
      end
      if (res_valid) begin
        int tt = oc / NP, q = NP - 1 - (oc % NP);
        for (int r = 0; r < N; r++) begin
          logic [AW-1:0] e = AW'(exp_m[tt < MAXT ? tt : 0][r][q / P][q % P]);
          // R3 R4 R5 R6: value, drain order and tile order
          check(c_out[r*AW +: AW] == e, "R4", "result word",
                longint'(c_out[r*AW +: AW]), longint'(e));
        end
        oc++;
        last_res = cyc;
      end
      if (done && done_cyc < 0) begin done_cnt++; done_cyc = cyc; end
      if (pre_take) begin
        int tt = lc / NP, q = NP - 1 - (lc % NP);
        for (int r = 0; r < N; r++)
          c_in[r*AW +: AW] = AW'(init_m[tt < MAXT ? tt : 0][r][q / P][q % P]);
        lc++;
      end else begin
        // R10: junk on c_in while not taken
        for (int r = 0; r < N; r++) c_in[r*AW +: AW] = AW'($urandom);
      end
      if (ab_ready && uc < t * k) begin
        int tt = uc / k, u = uc % k;
        for (int r = 0; r < N; r++) begin
          a_vec[r*DW +: DW] = DW'(av[tt][u][r]);
          b_vec[r*DW +: DW] = DW'(bv[tt][u][r]);
        end
        ab_valid = 1'b1;
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
        uc++;
      end else begin
        // R10: valid asserted with junk operands while not ready
        a_vec = N*DW'($urandom);
        b_vec = N*DW'($urandom);
        ab_valid = 1'b1;
        if (pre_take && first_acc < 0) pre_before++;
      end
      if (cyc > 3000) begin
        check(1'b0, "R9", "watchdog, run did not end", cyc, 0);
        fin = 1'b1;
      end
    end
    ab_valid = 1'b0;
    check(uc == t * k, "R3", "updates accepted", uc, t * k);
    check(pre_before == NP, "R2", "preload cycles before first update", pre_before, NP);
    check(lc == t * NP, "R6", "preload words consumed", lc, t * NP);
    check(oc == t * NP, "R5", "result words delivered", oc, t * NP);
    check(done_cnt == 1 && done_cyc == last_res + 1, "R9", "done cycle",
          done_cyc, last_res + 1);
    check(!busy, "R9", "busy after done", longint'(busy), 0);
    if (k > NP)
      check(last_acc - first_acc + 1 == t * k, "R7", "accept span",
            last_acc - first_acc + 1, t * k);
    if (k < NP && t > 1)
      check(last_acc - first_acc + 1 > t * k, "R8", "stall present",
            last_acc - first_acc + 1, t * k + 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ab_ready && !pre_take && !res_valid && !busy && !done, "R1",
          "idle outputs after reset",
          longint'({ab_ready, pre_take, res_valid, busy, done}), 0);
    run_case(16, 3);
    run_case(2, 2);
    run_case(8, 1);
    run_case(10, 4);
    run_case(4, 3);
    run_case(2, 1);
    run_case(16, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule